// File: doc/BRIEF.md
# Three-Wire Serial Slave Shift Unit

This block is the slave side of a three-wire serial link: the master drives a serial clock, the slave takes in one data line and drives one data line back. An 8-bit shift register moves one bit in on a chosen kind of serial clock edge, rising or falling. A 4-bit edge counter advances on every serial clock edge of both kinds, so one byte spans sixteen edges. When the counter wraps, a completion flag is raised and the received byte is copied into a buffer register. Software can then read the byte from the buffer register at leisure instead of from the live shifter.

The serial clock and data inputs are brought into the system clock domain through a two-flop synchroniser. Edges are detected there, so the system clock must run at least four times faster than the serial clock. Software reaches the block through a four-entry register window. The entries hold the mode, a status word (flag and counter), the shift register and the buffer. Writing the status word presets the counter, which lets software line up the wrap with the master's idle clock level.

Top module: `serial_slave_shifter`

## Requirements
- R1: After reset, all four registers read 0 and the serial output is 0.
- R2: The counter advances by one on every synchronised serial clock edge, rising and falling, only while the mode register holds 0x18 (bit 4 three-wire mode, bits 3:2 = 2'b10, shift on rising edge) or 0x1C (bits 3:2 = 2'b11, shift on falling edge). With any other mode it neither counts nor shifts.
- R3: On the edge where the counter wraps from 15 to 0, the completion flag (status bit 6) becomes 1.
- R4: On the wrapping edge, the buffer takes the shift register's value as it stands after that edge's shift, if there is one. At all other times the buffer holds its value.
- R5: On a selected shift edge, the shift register moves left by one: the synchronised input bit enters at bit 0 and bit 7 leaves. The serial output always shows bit 7.
- R6: Writing status with bit 6 set clears the flag. Writing status with bit 6 clear leaves the flag unchanged.
- R7: A status write loads the counter from bits 3:0 of the written value, and this load wins over a serial edge in the same system cycle.
- R8: A software write to the shift register wins over a shift in the same system cycle.
- R9: With an idle-low master clock and falling shift with preset 0 or rising shift with preset 1, or with an idle-high clock and rising shift with preset 0 or falling shift with preset 1, the buffer equals the received byte n for every n, and never ((n<<1)|(n&1)) & 0xFF where that differs from n.
- R10: A byte written to the shift register is returned to the master MSB first during the next transfer.
- R11: Register addresses: 0 mode (only bits 4:2 kept, others read 0), 1 status (bit 6 flag, bits 3:0 counter, others read 0), 2 shift register, 3 buffer (read-only, writes ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register window address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| regRdData | output | 8 | Register read value for regAddr |
| sclkIn | input | 1 | Serial clock from the master |
| sdiIn | input | 1 | Serial data from the master |
| sdoOut | output | 1 | Serial data to the master |

## Verification
The hardest situation to reach from the ports is a software write landing in exactly the system cycle where a synchronised serial edge acts. This applies both to the shift register write against a shift and to the counter preset against a count. The bench gets there by changing the serial clock just after a system clock edge and then counting the two synchroniser stages. It asserts the write strobe for the third edge only. The buffer-alignment rule is covered by a sweep of all 256 byte values through each of the four idle-level and preset pairings. The bench master samples the slave output at each shift edge, and every buffer value is compared with both the sent byte and the misaligned pattern.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = $clog2(2 * DATA_W);
  localparam int REG_W    = 8;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_BUF  = 2'd3;

  localparam int FLAG_BIT = 6;
  localparam int WIRE_BIT = 4;
  localparam int EXT_BIT  = 3;
  localparam int FALL_BIT = 2;

  typedef struct packed {
    logic countEdge;
    logic shiftEdge;
    logic capture;
    logic dataWr;
    logic sdiBit;
  } strobes_t;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/sss_ctrl.sv
module sss_ctrl
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             sclkIn,
  input  logic             sdiIn,
  output strobes_t         stb,
  output logic [REG_W-1:0] modeRead,
  output logic [REG_W-1:0] statRead,
  output logic [CNT_W-1:0] cntVal,
  output logic             flagVal
);
  logic [1:0] syncOut;
  logic       sclkPrev;
  logic [2:0] modeBits;
  logic       modeWr, statWr, enabled, riseDet, fallDet, wrapNow;
  logic       unusedBits;

  sss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({sclkIn, sdiIn}),
    .syncOut (syncOut)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclkPrev <= 1'b0;
    else        sclkPrev <= syncOut[1];
  end

  assign modeWr  = regWrEn && (regAddr == ADDR_MODE);
  assign statWr  = regWrEn && (regAddr == ADDR_STAT);
  assign enabled = modeBits[2] && modeBits[1];
  assign riseDet = syncOut[1] && !sclkPrev;
  assign fallDet = !syncOut[1] && sclkPrev;

  always_comb begin
    stb.countEdge = enabled && (riseDet || fallDet);
    stb.shiftEdge = enabled && (modeBits[0] ? fallDet : riseDet);
    stb.dataWr    = regWrEn && (regAddr == ADDR_DATA);
    stb.sdiBit    = syncOut[0];
    wrapNow       = stb.countEdge && !statWr && (cntVal == {CNT_W{1'b1}});
    stb.capture   = wrapNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      modeBits <= '0;
    else if (modeWr) modeBits <= regWrData[WIRE_BIT:FALL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cntVal <= '0;
    else if (statWr)         cntVal <= regWrData[CNT_W-1:0];
    else if (stb.countEdge)  cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            flagVal <= 1'b0;
    else if (wrapNow)                      flagVal <= 1'b1;
    else if (statWr && regWrData[FLAG_BIT]) flagVal <= 1'b0;
  end

  always_comb begin
    modeRead = '0;
    modeRead[WIRE_BIT:FALL_BIT] = modeBits;
    statRead = '0;
    statRead[FLAG_BIT]  = flagVal;
    statRead[CNT_W-1:0] = cntVal;
  end

  assign unusedBits = ^{regWrData[7], regWrData[5]};
endmodule

// File: rtl/sss_datapath.sv
module sss_datapath
  import sss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataVal,
  output logic [DATA_W-1:0] bufVal,
  output logic              sdoOut
);
  logic [DATA_W-1:0] afterEdge;

  assign afterEdge = stb.shiftEdge ? {dataVal[DATA_W-2:0], stb.sdiBit} : dataVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dataVal <= '0;
    else if (stb.dataWr) dataVal <= wrData;
    else                 dataVal <= afterEdge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bufVal <= '0;
    else if (stb.capture) bufVal <= afterEdge;
  end

  assign sdoOut = dataVal[DATA_W-1];
endmodule

// File: rtl/serial_slave_shifter.sv
module serial_slave_shifter
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclkIn,
  input  logic       sdiIn,
  output logic       sdoOut
);
  strobes_t          stb;
  logic [REG_W-1:0]  modeRead, statRead;
  logic [CNT_W-1:0]  cntVal;
  logic              flagVal;
  logic [DATA_W-1:0] dataVal, bufVal;

  sss_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .sclkIn    (sclkIn),
    .sdiIn     (sdiIn),
    .stb       (stb),
    .modeRead  (modeRead),
    .statRead  (statRead),
    .cntVal    (cntVal),
    .flagVal   (flagVal)
  );

  sss_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wrData  (regWrData),
    .dataVal (dataVal),
    .bufVal  (bufVal),
    .sdoOut  (sdoOut)
  );

  always_comb begin
    case (regAddr)
      ADDR_MODE: regRdData = modeRead;
      ADDR_STAT: regRdData = statRead;
      ADDR_DATA: regRdData = dataVal;
      default:   regRdData = bufVal;
    endcase
  end
endmodule

// File: rtl/sss_checker.sv
module sss_checker
  import sss_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input strobes_t          stb,
  input logic [CNT_W-1:0]  cntVal,
  input logic              flagVal,
  input logic [DATA_W-1:0] dataVal,
  input logic [DATA_W-1:0] bufVal
);
  logic statWr, dataWr;
  assign statWr = regWrEn && (regAddr == ADDR_STAT);
  assign dataWr = regWrEn && (regAddr == ADDR_DATA);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.countEdge && !statWr |=> cntVal == $past(cntVal) + 4'd1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.countEdge && !statWr |=> $stable(cntVal));

  p_flag_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.countEdge && !statWr && cntVal == 4'hF |=> flagVal && cntVal == 4'd0);

  p_buf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.capture |=> $stable(bufVal));

  p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shiftEdge && !dataWr |=> dataVal[7:1] == $past(dataVal[6:0]));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    statWr && regWrData[6] && !(stb.countEdge && cntVal == 4'hF) |=> !flagVal);

  p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    statWr |=> cntVal == $past(regWrData[3:0]));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dataWr |=> dataVal == $past(regWrData));
endmodule

bind serial_slave_shifter sss_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .stb       (stb),
  .cntVal    (cntVal),
  .flagVal   (flagVal),
  .dataVal   (dataVal),
  .bufVal    (bufVal)
);

// File: tb/tb_serial_slave_shifter.sv
`timescale 1ns/1ps
module tb_serial_slave_shifter;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sclkIn = 1'b0;
  logic       sdiIn = 1'b0;
  logic       sdoOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_slave_shifter dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .sclkIn(sclkIn), .sdiIn(sdiIn), .sdoOut(sdoOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Serial edge whose action lands in the same system cycle as a register write.
  task automatic edgeWithWrite(input logic lvl, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sclkIn = lvl;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    waitCyc(4);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit idleHigh, input bit riseShift,
                      output logic [7:0] rx);
    logic lvl;
    int b;
    bit isShift;
    lvl = idleHigh;
    b = 7;
    rx = 8'd0;
    @(negedge clk);
    sdiIn = tx[7];
    waitCyc(H);
    for (int e = 0; e < 16; e++) begin
      lvl = !lvl;
      sclkIn = lvl;
      isShift = (lvl == riseShift);
      if (isShift) rx = {rx[6:0], sdoOut};
      waitCyc(H);
      if (isShift && b > 0) begin
        b--;
        sdiIn = tx[b];
      end
    end
    waitCyc(4);
  endtask

  task automatic sweep(input bit idleHigh, input bit riseShift, input logic [3:0] preset);
    logic [7:0] rd, rx, echoVal, faulty;
    string cfg;
    cfg = $sformatf("idle%0d rise%0d preset%0d", idleHigh, riseShift, preset);
    regWrite(2'd0, 8'd0);
    @(negedge clk) sclkIn = idleHigh;
    waitCyc(6);
    regWrite(2'd0, riseShift ? 8'h18 : 8'h1C);
    regWrite(2'd1, {4'h4, preset});
    echoVal = 8'hA5;
    regWrite(2'd2, echoVal);
    for (int n = 0; n < 256; n++) begin
      xfer(n[7:0], idleHigh, riseShift, rx);
      check(rx == echoVal, {"R10 echo ", cfg}, rx, echoVal);
      regRead(2'd1, rd);
      check(rd == {4'h4, preset}, {"R3 flag/count ", cfg}, rd, {4'h4, preset});
      regRead(2'd3, rd);
      check(rd == n[7:0], {"R9 buffer ", cfg}, rd, n);
      faulty = {n[6:0], n[0]};
      if (faulty != n[7:0])
        check(rd != faulty, {"R9 misaligned pattern ", cfg}, rd, n);
      echoVal = rd;
      regWrite(2'd2, echoVal);
      regWrite(2'd1, {4'h4, preset});
    end
    regRead(2'd1, rd);
    check(rd[6] == 1'b0, {"R6 flag cleared ", cfg}, rd, {4'h0, preset});
    regWrite(2'd0, 8'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(3);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(a[1:0], rd);
      check(rd == 8'd0, "R1 reset register", rd, 0);
    end
    check(sdoOut == 1'b0, "R1 reset sdo", sdoOut, 0);

    // R11 address map
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, rd);
    check(rd == 8'h1C, "R11 mode bits kept", rd, 8'h1C);
    regWrite(2'd3, 8'h3C);
    regRead(2'd3, rd);
    check(rd == 8'h00, "R11 buffer read-only", rd, 0);
    regWrite(2'd0, 8'h00);

    // R2 disabled: no count, no shift; R5 sdo shows bit 7
    regWrite(2'd2, 8'h81);
    check(sdoOut == 1'b1, "R5 sdo is msb", sdoOut, 1);
    sdiIn = 1'b1;
    for (int e = 0; e < 4; e++) begin
      @(negedge clk) sclkIn = ~sclkIn;
      waitCyc(H);
    end
    regRead(2'd1, rd);
    check(rd == 8'h00, "R2 disabled no count", rd, 0);
    regRead(2'd2, rd);
    check(rd == 8'h81, "R2 disabled no shift", rd, 8'h81);

    // R2/R5 enabled, rising shift: one rise then one fall
    regWrite(2'd0, 8'h18);
    @(negedge clk) sclkIn = 1'b1;
    waitCyc(H);
    @(negedge clk) sclkIn = 1'b0;
    waitCyc(H);
    regRead(2'd2, rd);
    check(rd == 8'h03, "R5 shift left lsb in", rd, 8'h03);
    check(sdoOut == 1'b0, "R5 sdo after shift", sdoOut, 0);
    regRead(2'd1, rd);
    check(rd == 8'h02, "R2 both edges counted", rd, 8'h02);

    // R8 data write beats a shift in the same cycle
    edgeWithWrite(1'b1, 2'd2, 8'h5A);
    regRead(2'd2, rd);
    check(rd == 8'h5A, "R8 write wins over shift", rd, 8'h5A);
    regRead(2'd1, rd);
    check(rd == 8'h03, "R2 count with data write", rd, 8'h03);

    // R7 preset beats an edge in the same cycle
    edgeWithWrite(1'b0, 2'd1, 8'h09);
    regRead(2'd1, rd);
    check(rd == 8'h09, "R7 preset wins over edge", rd, 8'h09);

    // R3/R4 wrap on a shift edge
    regWrite(2'd1, 8'h0F);
    @(negedge clk) sclkIn = 1'b1;
    waitCyc(H);
    regRead(2'd1, rd);
    check(rd == 8'h40, "R3 wrap sets flag", rd, 8'h40);
    regRead(2'd3, rd);
    check(rd == 8'hB5, "R4 buffer takes post-shift value", rd, 8'hB5);

    // R6 clear rules
    regWrite(2'd1, 8'h00);
    regRead(2'd1, rd);
    check(rd == 8'h40, "R6 write 0 keeps flag", rd, 8'h40);
    regWrite(2'd1, 8'h40);
    regRead(2'd1, rd);
    check(rd == 8'h00, "R6 write 1 clears flag", rd, 0);
    regWrite(2'd0, 8'h00);

    // R9/R10 sweeps over all idle-level and preset pairings
    sweep(1'b0, 1'b0, 4'd0);
    sweep(1'b0, 1'b1, 4'd1);
    sweep(1'b1, 1'b1, 4'd0);
    sweep(1'b1, 1'b0, 4'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule